// File: doc/BRIEF.md
# Arithmetic-Logic Unit with Condition Flags

This block is the arithmetic and logic core of a small accumulator or register machine. Each cycle it takes two W-bit operands and a 4-bit operation code and produces, without any register on the path, a W-bit result, a result write-enable for the destination register, and a fresh set of four condition flags: negative, zero, overflow and carry. A status register inside the block captures those flags on a clock edge when the flag-write enable is high. Its stored carry is fed back as the carry input of the carry-chained operations, and its contents are visible to branch logic.

All arithmetic goes through one adder. Subtraction adds the inverted second operand and a carry-in of one. Overflow is the exclusive-or of the carry into the sign bit and the carry out of it. The carry flag is the raw adder carry for every arithmetic operation, so after a subtraction a set carry means no borrow occurred. Compare and test drive the flags the way subtract and AND do, but they withhold the result write-enable. A branch can therefore act on a comparison without changing any register.

Top module: `alu_flag_unit`

## Requirements
- R1: Code 0 (add) gives a+b and code 1 (add with carry) gives a+b+Cs, both modulo 2^W, where Cs is the stored carry flag. The result write-enable is high for both.
- R2: Code 2 (subtract) gives a + ~b + 1 and code 3 (subtract with borrow) gives a + ~b + Cs, both modulo 2^W. The result write-enable is high for both.
- R3: Code 4 (increment) gives a+1, code 5 (decrement) gives a-1 computed as a + all-ones, and code 6 (negate) gives 0 + ~a + 1. All are modulo 2^W.
- R4: Codes 8 (AND), 9 (OR), 10 (XOR), 11 (complement of a) and 12 (clear to zero) produce the bitwise result, with the result write-enable high.
- R5: The flag vector is {N,Z,V,C}, with N at bit 3 and C at bit 0. For every defined code, N equals the result's top bit and Z is high exactly when all result bits are zero.
- R6: For codes 0 to 7, V is the carry into the top bit of the adder XOR the carry out of it. This equals signed overflow of x+y+cin.
- R7: For codes 0 to 7, C is the raw carry out of the adder's top bit, with no borrow inversion. With W=8, subtracting 8'h14 from 8'hF0 yields 8'hDC with N=1, Z=0, V=0, C=1.
- R8: For codes 8 to 13, V is 0 and C equals the stored carry.
- R9: Code 7 (compare) computes the flags of subtraction and code 13 (test) computes the flags of AND. For both, the result write-enable is low. For codes 0 to 6 and 8 to 12 it is high.
- R10: The status register is all zero after reset. It loads the present flags on a rising clock edge when the flag-write enable is high, and otherwise holds its value.
- R11: Codes 14 and 15 are undefined. They give a zero result, a low result write-enable, and present flags equal to the stored flags, so a flag write leaves the status register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the status register |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_in | input | W | First operand |
| b_in | input | W | Second operand or mask |
| op_code | input | 4 | Operation code |
| flag_we | input | 1 | Status register write enable |
| result_o | output | W | Operation result |
| result_we_o | output | 1 | Result may be written back |
| flags_now_o | output | 4 | Flags of the present operation {N,Z,V,C} |
| flags_q_o | output | 4 | Stored status flags {N,Z,V,C} |

## Verification
The main instance is built with W=4 and the bit-by-bit ripple adder. At that width, every operation code, every operand pair and both values of the stored carry can be swept in full. That sweep reaches every overflow and carry boundary, including the most-negative value under negate and the all-ones and all-zero operands. A second instance is built with W=8 and the split adder variant. It confirms the 8-bit subtraction case from R7 and exercises the other generate branch. Directed clocked sequences cover loading, holding and resetting the status register.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

   typedef enum logic [3:0] {
      OP_ADD = 4'd0,
      OP_ADC = 4'd1,
      OP_SUB = 4'd2,
      OP_SBB = 4'd3,
      OP_INC = 4'd4,
      OP_DEC = 4'd5,
      OP_NEG = 4'd6,
      OP_CMP = 4'd7,
      OP_AND = 4'd8,
      OP_OR  = 4'd9,
      OP_XOR = 4'd10,
      OP_NOT = 4'd11,
      OP_CLR = 4'd12,
      OP_TST = 4'd13
   } alu_op_e;

   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } alu_flags_t;

   localparam int unsigned FLAG_BITS = 4;
   localparam logic [3:0]  OP_LAST_DEFINED = 4'd13;

endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
   parameter int unsigned W      = 8,
   parameter bit          RIPPLE = 1'b1
) (
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] y_i,
   input  logic         ci_i,
   output logic [W-1:0] sum_o,
   output logic         c_msb_o,
   output logic         c_out_o
);

   if (RIPPLE) begin : g_ripple
      logic [W:0] chain;
      assign chain[0] = ci_i;
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign sum_o[i]    = x_i[i] ^ y_i[i] ^ chain[i];
         assign chain[i+1]  = (x_i[i] & y_i[i]) | (chain[i] & (x_i[i] ^ y_i[i]));
      end
      assign c_msb_o = chain[W-1];
      assign c_out_o = chain[W];
   end else begin : g_split
      logic [W-1:0] low;
      logic [1:0]   top;
      assign low     = {1'b0, x_i[W-2:0]} + {1'b0, y_i[W-2:0]} + {{(W-1){1'b0}}, ci_i};
      assign c_msb_o = low[W-1];
      assign top     = {1'b0, x_i[W-1]} + {1'b0, y_i[W-1]} + {1'b0, c_msb_o};
      assign sum_o   = {top[0], low[W-2:0]};
      assign c_out_o = top[1];
   end

endmodule

// File: rtl/alu_operand_sel.sv
module alu_operand_sel
   import alu_flag_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic [3:0]   op_i,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic         c_stored_i,
   output logic [W-1:0] x_o,
   output logic [W-1:0] y_o,
   output logic         ci_o,
   output logic         arith_o
);

   localparam logic [W-1:0] ALL_ZERO = '0;
   localparam logic [W-1:0] ALL_ONES = '1;

   always_comb begin
      x_o     = a_i;
      y_o     = b_i;
      ci_o    = 1'b0;
      arith_o = 1'b1;
      case (alu_op_e'(op_i))
         OP_ADD: ;
         OP_ADC: ci_o = c_stored_i;
         OP_SUB, OP_CMP: begin
            y_o  = ~b_i;
            ci_o = 1'b1;
         end
         OP_SBB: begin
            y_o  = ~b_i;
            ci_o = c_stored_i;
         end
         OP_INC: begin
            y_o  = ALL_ZERO;
            ci_o = 1'b1;
         end
         OP_DEC: y_o = ALL_ONES;
         OP_NEG: begin
            x_o  = ALL_ZERO;
            y_o  = ~a_i;
            ci_o = 1'b1;
         end
         default: arith_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
   import alu_flag_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic [3:0]   op_i,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] res_o
);

   always_comb begin
      case (alu_op_e'(op_i))
         OP_AND, OP_TST: res_o = a_i & b_i;
         OP_OR:          res_o = a_i | b_i;
         OP_XOR:         res_o = a_i ^ b_i;
         OP_NOT:         res_o = ~a_i;
         default:        res_o = '0;
      endcase
   end

endmodule

// File: rtl/alu_status_reg.sv
module alu_status_reg
   import alu_flag_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       we_i,
   input  alu_flags_t d_i,
   output alu_flags_t q_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q_o <= '0;
      else if (we_i) q_o <= d_i;
   end

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
   import alu_flag_pkg::*;
#(
   parameter int unsigned W            = 8,
   parameter bit          RIPPLE_ADDER = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [W-1:0]         a_in,
   input  logic [W-1:0]         b_in,
   input  logic [3:0]           op_code,
   input  logic                 flag_we,
   output logic [W-1:0]         result_o,
   output logic                 result_we_o,
   output logic [FLAG_BITS-1:0] flags_now_o,
   output logic [FLAG_BITS-1:0] flags_q_o
);

   if (W < 2) begin : g_bad_width
      $error("alu_flag_unit: W must be at least 2");
   end

   alu_flags_t   stored, present;
   logic [W-1:0] x, y, sum, lres;
   logic         ci, arith, c_msb, c_out, defined, no_wb;

   alu_operand_sel #(.W(W)) u_sel (
      .op_i(op_code), .a_i(a_in), .b_i(b_in), .c_stored_i(stored.c),
      .x_o(x), .y_o(y), .ci_o(ci), .arith_o(arith)
   );

   alu_adder #(.W(W), .RIPPLE(RIPPLE_ADDER)) u_add (
      .x_i(x), .y_i(y), .ci_i(ci),
      .sum_o(sum), .c_msb_o(c_msb), .c_out_o(c_out)
   );

   alu_logic_unit #(.W(W)) u_logic (
      .op_i(op_code), .a_i(a_in), .b_i(b_in), .res_o(lres)
   );

   assign defined = (op_code <= OP_LAST_DEFINED);
   assign no_wb   = (op_code == OP_CMP) || (op_code == OP_TST);

   always_comb begin
      if (!defined) begin
         result_o = '0;
         present  = stored;
      end else if (arith) begin
         result_o  = sum;
         present.n = sum[W-1];
         present.z = ~|sum;
         present.v = c_msb ^ c_out;
         present.c = c_out;
      end else begin
         result_o  = lres;
         present.n = lres[W-1];
         present.z = ~|lres;
         present.v = 1'b0;
         present.c = stored.c;
      end
   end

   assign result_we_o = defined && !no_wb;
   assign flags_now_o = present;
   assign flags_q_o   = stored;

   alu_status_reg u_status (
      .clk(clk), .rst_n(rst_n), .we_i(flag_we), .d_i(present), .q_o(stored)
   );

endmodule

// File: rtl/alu_flag_unit_chk.sv
module alu_flag_unit_chk #(
   parameter int unsigned W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic [3:0]   op_code,
   input logic         flag_we,
   input logic [W-1:0] result_o,
   input logic         result_we_o,
   input logic [3:0]   flags_now_o,
   input logic [3:0]   flags_q_o
);

   logic is_logic, is_defined;
   assign is_logic   = (op_code >= 4'd8) && (op_code <= 4'd13);
   assign is_defined = (op_code <= 4'd13);

   // R10: load on enable, hold otherwise
   p_flag_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
      flag_we |=> (flags_q_o == $past(flags_now_o)));
   p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_we |=> $stable(flags_q_o));

   // R9: compare and test never write back
   p_no_wb_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((op_code == 4'd7) || (op_code == 4'd13)) |-> !result_we_o);

   // R5: zero and negative follow the result
   p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      is_defined |-> (flags_now_o[2] == (result_o == '0)));
   p_neg_r5: assert property (@(posedge clk) disable iff (!rst_n)
      is_defined |-> (flags_now_o[3] == result_o[W-1]));

   // R8: logic ops clear V and pass the stored carry
   p_logic_vc_r8: assert property (@(posedge clk) disable iff (!rst_n)
      is_logic |-> (!flags_now_o[1] && (flags_now_o[0] == flags_q_o[0])));

   // R11: undefined codes are inert
   p_unused_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !is_defined |-> (!result_we_o && (flags_now_o == flags_q_o)));

endmodule

bind alu_flag_unit alu_flag_unit_chk #(.W(W)) u_chk (.*);

// File: tb/tb_alu_flag_unit.sv
`timescale 1ns/1ps
module tb_alu_flag_unit;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] a_in = '0, b_in = '0, op_code = '0;
   logic       flag_we = 1'b0;
   logic [3:0] result_o, flags_now_o, flags_q_o;
   logic       result_we_o;

   logic [7:0] a8 = '0, b8 = '0, r8;
   logic [3:0] op8 = '0, fn8, fq8;
   logic       we8;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   alu_flag_unit #(.W(4), .RIPPLE_ADDER(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .op_code(op_code),
      .flag_we(flag_we), .result_o(result_o), .result_we_o(result_we_o),
      .flags_now_o(flags_now_o), .flags_q_o(flags_q_o)
   );

   alu_flag_unit #(.W(8), .RIPPLE_ADDER(1'b0)) dut_w8 (
      .clk(clk), .rst_n(rst_n), .a_in(a8), .b_in(b8), .op_code(op8),
      .flag_we(1'b0), .result_o(r8), .result_we_o(we8),
      .flags_now_o(fn8), .flags_q_o(fq8)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h (op=%0d a=%0h b=%0h)",
                  tag, act, exp, op_code, a_in, b_in);
      end
   endtask

   function automatic int sgn4(input int v);
      return (v >= 8) ? v - 16 : v;
   endfunction

   // Expected outputs from the requirements, width 4
   task automatic model(input int op, input int a, input int b, input int sq,
                        output int res, output int we, output int fl, output bit arith);
      int x, y, ci, s, sv, n, z, v, c;
      int cq;
      cq = sq & 1;
      arith = 1'b1;
      x = a; y = b; ci = 0;
      case (op)
         0: ;
         1: ci = cq;
         2, 7: begin y = 15 - b; ci = 1; end
         3: begin y = 15 - b; ci = cq; end
         4: begin y = 0; ci = 1; end
         5: y = 15;
         6: begin x = 0; y = 15 - a; ci = 1; end
         default: arith = 1'b0;
      endcase
      if (op >= 14) begin
         res = 0; we = 0; fl = sq;
         return;
      end
      if (arith) begin
         s   = x + y + ci;
         res = s % 16;
         c   = s / 16;
         sv  = sgn4(x) + sgn4(y) + ci;
         v   = (sv > 7 || sv < -8) ? 1 : 0;
      end else begin
         case (op)
            8, 13: res = a & b;
            9:     res = a | b;
            10:    res = a ^ b;
            11:    res = 15 - a;
            default: res = 0;
         endcase
         v = 0; c = cq;
      end
      n  = (res >= 8) ? 1 : 0;
      z  = (res == 0) ? 1 : 0;
      we = (op == 7 || op == 13) ? 0 : 1;
      fl = n * 8 + z * 4 + v * 2 + c;
   endtask

   function automatic string res_tag(input int op);
      case (op)
         0, 1:    return "R1";
         2, 3:    return "R2";
         4, 5, 6: return "R3";
         7, 13:   return "R9";
         14, 15:  return "R11";
         default: return "R4";
      endcase
   endfunction

   // Drive a flag write with flag_we, then sample the stored flags
   task automatic write_flags(input int op, input int a, input int b,
                              input int exp, input string tag);
      @(negedge clk);
      op_code = 4'(op); a_in = 4'(a); b_in = 4'(b); flag_we = 1'b1;
      @(negedge clk);
      flag_we = 1'b0;
      #1;
      chk(flags_q_o == 4'(exp), tag, flags_q_o, exp);
   endtask

   initial begin : watchdog
      #1000000;
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      int eres, ewe, efl, sq;
      bit earith;
      repeat (3) @(negedge clk);
      #1;
      chk(flags_q_o == 4'h0, "R10 reset", flags_q_o, 0);
      rst_n = 1'b1;

      for (int cq = 0; cq < 2; cq++) begin
         // R10: ADD 15+1 -> {N,Z,V,C}=0101, ADD 0+0 -> 0100
         if (cq == 1) write_flags(0, 15, 1, 4'b0101, "R10 load");
         else         write_flags(0, 0, 0, 4'b0100, "R10 load");
         sq = (cq == 1) ? 4'b0101 : 4'b0100;
         for (int op = 0; op < 16; op++) begin
            for (int a = 0; a < 16; a++) begin
               for (int b = 0; b < 16; b++) begin
                  op_code = 4'(op); a_in = 4'(a); b_in = 4'(b);
                  #1;
                  model(op, a, b, sq, eres, ewe, efl, earith);
                  chk(result_o == 4'(eres), res_tag(op), result_o, eres);
                  chk(result_we_o == ewe[0], "R9 write-enable", result_we_o, ewe);
                  if (op >= 14) begin
                     chk(flags_now_o == 4'(efl), "R11 flags", flags_now_o, efl);
                  end else begin
                     chk(flags_now_o[3:2] == 2'(efl >> 2), "R5 N/Z", flags_now_o[3:2], efl >> 2);
                     chk(flags_now_o[1] == efl[1], earith ? "R6 V" : "R8 V",
                         flags_now_o[1], efl[1]);
                     chk(flags_now_o[0] == efl[0], earith ? "R7 C" : "R8 C",
                         flags_now_o[0], efl[0]);
                  end
               end
            end
         end
         chk(flags_q_o == 4'(sq), "R10 hold", flags_q_o, sq);
      end

      // R10/R2: SUB 3-5 -> result 14, flags 1000
      write_flags(2, 3, 5, 4'b1000, "R2 flag write");
      // R9: CMP 5,5 still updates flags -> 0101
      write_flags(7, 5, 5, 4'b0101, "R9 compare flags");
      // R1: ADC 7+0 with stored C=1 -> 8, flags 1010
      write_flags(1, 7, 0, 4'b1010, "R1 adc overflow");
      // R11: undefined code with flag write leaves stored flags
      write_flags(14, 9, 9, 4'b1010, "R11 no change");
      // R9: TST 0xA & 0x5 = 0 -> Z, C from stored (0) -> 0100
      write_flags(13, 10, 5, 4'b0100, "R9 test flags");

      // R7: 8-bit subtract example
      @(negedge clk);
      op8 = 4'd2; a8 = 8'hF0; b8 = 8'h14;
      #1;
      chk(r8 == 8'hDC, "R7 w8 result", r8, 8'hDC);
      chk(fn8 == 4'b1001, "R7 w8 flags", fn8, 4'b1001);
      chk(we8 == 1'b1, "R7 w8 write-enable", we8, 1);
      op8 = 4'd7;
      #1;
      chk(we8 == 1'b0 && fn8 == 4'b1001, "R9 w8 compare", {we8, fn8}, 5'b01001);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule